// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the settings a PLL clock synthesizer reads: a 9-bit feedback divider value, a 2-bit output divider code and a 2-bit selector for a test pin. The dividers, oscillator and analog outputs sit elsewhere. This block only produces the divider values and the test pin.

The settings can be loaded in two ways, and both write the same registers. In parallel mode an active-low load strobe passes the divider pins straight through while it is low and latches them on its rising edge. In serial mode a 14-bit frame is shifted in, one bit on each rising edge of a serial clock, and a separate load strobe commits it. The frame starts with the two test-select bits, then a dummy slot that is thrown away, then the output divider code and the feedback value, most significant bit first. While the serial strobe is held high, every shift goes straight to the registers. Its falling edge freezes them.

The strobes, serial clock and data are sampled on the system clock, and their edges are found by comparing each sample with the previous one. A flag marks feedback values outside the lock range. The test pin passes one of four sources, selected by the test bits. It is forced low whenever parallel mode is active.

Top module: `syncfg_top`

## Requirements
- R1: Synchronous reset sets the feedback value to parameter M_DEFAULT (20), the output code to N_DEFAULT (1) and the test selector to 00, so test_out is 0 after reset. An edge on an input during reset is not seen as a load event.
- R2: While pl_n is 0, m_div and n_div show par_m and par_n from the previous clock.
- R3: On the clock where pl_n goes from 0 to 1, the pins are latched. Later changes on par_m and par_n have no effect while pl_n stays 1.
- R4: With pl_n=1 and sl=0, each rising edge of ser_clk shifts ser_data into the shift register. m_div and n_div do not change.
- R5: Frame bits arrive in this order: T1, T0, a dummy slot, N1, N0, M8 down to M0. The dummy bit never reaches any output.
- R6: A 0-to-1 edge of sl while pl_n=1 copies the shift register into the feedback value, the output code and the test selector.
- R7: While sl stays 1 and pl_n=1, each rising edge of ser_clk shifts and updates the registers on the same clock.
- R8: After sl falls, the registers hold their values while further frames are shifted in.
- R9: With pl_n=1, test_out follows the test selector: 00 gives 0, 01 gives ser_data, 10 gives mfb_in, 11 gives fout_in.
- R10: test_out is 0 whenever pl_n is 0, whatever the selector holds.
- R11: m_bad is 1 exactly when m_div is below 8 or above 28.
- R12: If pl_n rises on the same clock as sl rises, the parallel pins are loaded and the frame is not.
- R13: A serial commit after a parallel latch replaces the latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_n | input | 1 | Parallel load strobe, active low |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_data | input | 1 | Serial data |
| sl | input | 1 | Serial load strobe |
| mfb_in | input | 1 | Feedback divider output, test source |
| fout_in | input | 1 | Output clock copy, test source |
| m_div | output | 9 | Current feedback divider value |
| n_div | output | 2 | Current output divider code |
| m_bad | output | 1 | Feedback value outside 8..28 |
| test_out | output | 1 | Test pin |

## Verification
Two situations are hard to reach from the ports. The first is the pass-through window, where sl stays high while ser_clk keeps toggling. There, each shift must land in m_div on the clock after it, and the expected value is a running left shift of the frame that the bench tracks bit by bit. The second is the clock where pl_n and sl rise together. The bench reaches it by first shifting a complete frame with the serial strobe low, then dropping pl_n, then raising both strobes in the same clock, and it checks that the pins win.

// File: rtl/syncfg_pkg.sv
package syncfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + 1 + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] tsel;
    logic           dummy;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } frame_t;
endpackage

// File: rtl/syncfg_edge.sv
module syncfg_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    prev <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    assign rise[i] = !rst && sig[i] && !prev[i];
    assign fall[i] = !rst && !sig[i] && prev[i];
  end
endmodule

// File: rtl/syncfg_shreg.sv
module syncfg_shreg
  import syncfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shift_en,
  input  logic   din,
  output frame_t q,
  output frame_t q_next
);
  always_comb begin
    q_next = q;
    if (shift_en) q_next = frame_t'({q[FRAME_W-2:0], din});
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/syncfg_testmux.sv
module syncfg_testmux
  import syncfg_pkg::*;
(
  input  logic [T_W-1:0] sel,
  input  logic           par_mode,
  input  logic           sdata,
  input  logic           mfb,
  input  logic           fout,
  output logic           y
);
  always_comb begin
    if (par_mode) y = 1'b0;
    else begin
      unique case (sel)
        2'b00:   y = 1'b0;
        2'b01:   y = sdata;
        2'b10:   y = mfb;
        default: y = fout;
      endcase
    end
  end
endmodule

// File: rtl/syncfg_top.sv
module syncfg_top
  import syncfg_pkg::*;
#(
  parameter logic [M_W-1:0] M_DEFAULT = 9'd20,
  parameter logic [N_W-1:0] N_DEFAULT = 2'd1,
  parameter int             M_MIN     = 8,
  parameter int             M_MAX     = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pl_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           sl,
  input  logic           mfb_in,
  input  logic           fout_in,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_div,
  output logic           m_bad,
  output logic           test_out
);
  localparam int EDGES = 3;
  localparam int E_PL  = 0;
  localparam int E_SL  = 1;
  localparam int E_SC  = 2;

  logic [EDGES-1:0] rise, fall;
  logic             shift_en;
  frame_t           sr, sr_next;
  logic [T_W-1:0]   tsel;

  logic [M_W-1:0] m_d;
  logic [N_W-1:0] n_d;
  logic [T_W-1:0] t_d;

  function automatic logic out_of_range(input logic [M_W-1:0] v);
    return (int'(v) < M_MIN) || (int'(v) > M_MAX);
  endfunction

  syncfg_edge #(.W(EDGES)) u_edge (
    .clk (clk),
    .rst (rst),
    .sig ({ser_clk, sl, pl_n}),
    .rise(rise),
    .fall(fall)
  );

  assign shift_en = pl_n && rise[E_SC];

  syncfg_shreg u_shreg (
    .clk     (clk),
    .rst     (rst),
    .shift_en(shift_en),
    .din     (ser_data),
    .q       (sr),
    .q_next  (sr_next)
  );

  always_comb begin
    m_d = m_div;
    n_d = n_div;
    t_d = tsel;
    if (!pl_n || rise[E_PL]) begin
      m_d = par_m;
      n_d = par_n;
    end else if (rise[E_SL] || (sl && shift_en)) begin
      m_d = sr_next.m;
      n_d = sr_next.n;
      t_d = sr_next.tsel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_div <= M_DEFAULT;
      n_div <= N_DEFAULT;
      tsel  <= '0;
      m_bad <= out_of_range(M_DEFAULT);
    end else begin
      m_div <= m_d;
      n_div <= n_d;
      tsel  <= t_d;
      m_bad <= out_of_range(m_d);
    end
  end

  syncfg_testmux u_mux (
    .sel     (tsel),
    .par_mode(!pl_n),
    .sdata   (ser_data),
    .mfb     (mfb_in),
    .fout    (fout_in),
    .y       (test_out)
  );

  logic unused_fall;
  assign unused_fall = ^fall;
endmodule

// File: rtl/syncfg_checker.sv
module syncfg_checker
  import syncfg_pkg::*;
#(
  parameter logic [M_W-1:0] M_DEFAULT = 9'd20,
  parameter logic [N_W-1:0] N_DEFAULT = 2'd1,
  parameter int             M_MIN     = 8,
  parameter int             M_MAX     = 28
) (
  input logic           clk,
  input logic           rst,
  input logic           pl_n,
  input logic [M_W-1:0] par_m,
  input logic [N_W-1:0] par_n,
  input logic           sl,
  input logic [M_W-1:0] m_div,
  input logic [N_W-1:0] n_div,
  input logic           m_bad,
  input logic           test_out
);
  p_reset_defaults_r1: assert property (@(posedge clk)
    rst |=> (m_div == M_DEFAULT && n_div == N_DEFAULT));

  p_follow_pins_r2: assert property (@(posedge clk) disable iff (rst)
    !pl_n |=> (m_div == $past(par_m) && n_div == $past(par_n)));

  p_hold_while_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (pl_n && $past(pl_n) && !sl && !$past(sl)) |=> (m_div == $past(m_div)));

  p_test_low_par_r10: assert property (@(posedge clk) disable iff (rst)
    !pl_n |-> !test_out);

  p_range_flag_r11: assert property (@(posedge clk) disable iff (rst)
    m_bad == ((int'(m_div) < M_MIN) || (int'(m_div) > M_MAX)));
endmodule

bind syncfg_top syncfg_checker #(
  .M_DEFAULT(M_DEFAULT), .N_DEFAULT(N_DEFAULT), .M_MIN(M_MIN), .M_MAX(M_MAX)
) i_chk (
  .clk(clk), .rst(rst), .pl_n(pl_n), .par_m(par_m), .par_n(par_n), .sl(sl),
  .m_div(m_div), .n_div(n_div), .m_bad(m_bad), .test_out(test_out)
);

// File: tb/test_syncfg_top.sv
module test_syncfg_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  // each entry: {m[8:0], n[1:0], expected m_bad}
  localparam logic [11:0] VEC [NVEC] = '{
    {9'd8, 2'd0, 1'b0}, {9'd7, 2'd1, 1'b1}, {9'd28, 2'd2, 1'b0},
    {9'd29, 2'd3, 1'b1}, {9'd0, 2'd0, 1'b1}, {9'd511, 2'd1, 1'b1},
    {9'd15, 2'd2, 1'b0}
  };

  logic clk = 0, rst = 1, pl_n = 1, ser_clk = 0, ser_data = 0, sl = 0;
  logic mfb_in = 0, fout_in = 0;
  logic [8:0] par_m = 0;
  logic [1:0] par_n = 0;
  logic [8:0] m_div;
  logic [1:0] n_div;
  logic m_bad, test_out;
  int tests = 0, fails = 0;
  logic [13:0] shadow = 0;

  always #(CLK_P/2) clk = ~clk;

  syncfg_top i_syncfg_top (
    .clk(clk), .rst(rst), .pl_n(pl_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .sl(sl), .mfb_in(mfb_in),
    .fout_in(fout_in), .m_div(m_div), .n_div(n_div), .m_bad(m_bad),
    .test_out(test_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input logic dmy, input logic [1:0] n,
                      input logic [8:0] m, input bit pass);
    logic [13:0] fr;
    fr = {t, dmy, n, m};
    for (int i = 13; i >= 0; i--) begin
      ser_data = fr[i];
      ser_clk = 0; step();
      ser_clk = 1; step();
      shadow = {shadow[12:0], fr[i]};
      if (pass) chk("R7 pass-through", m_div, shadow[8:0]);
    end
    ser_clk = 0; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    pl_n = 0; step(); pl_n = 1; step();
    rst = 0; step();
    chk("R1 m default", m_div, 20);
    chk("R1 n default", n_div, 1);
    chk("R1 test low", test_out, 0);

    pl_n = 0;
    for (int k = 0; k < NVEC; k++) begin
      par_m = VEC[k][11:3]; par_n = VEC[k][2:1]; step();
      chk("R2 m follows", m_div, VEC[k][11:3]);
      chk("R2 n follows", n_div, VEC[k][2:1]);
      chk("R11 range flag", m_bad, VEC[k][0]);
    end

    par_m = 17; par_n = 2; step();
    pl_n = 1; step();
    chk("R3 latched", m_div, 17);
    par_m = 3; par_n = 0; step();
    chk("R3 pins ignored m", m_div, 17);
    chk("R3 pins ignored n", n_div, 2);

    send(2'b01, 1'b1, 2'd3, 9'd25, 0);
    chk("R4 hold during shift", m_div, 17);
    sl = 1; step();
    chk("R6 commit m", m_div, 25);
    chk("R5 n after dummy", n_div, 3);
    sl = 0; step();
    ser_data = 1; #1 chk("R9 sel01 data1", test_out, 1);
    ser_data = 0; #1 chk("R9 sel01 data0", test_out, 0);
    @(negedge clk);

    send(2'b00, 1'b0, 2'd0, 9'd9, 0);
    chk("R8 hold after fall", m_div, 25);
    sl = 1; step();
    chk("R6 commit 9", m_div, 9);
    send(2'b10, 1'b1, 2'd0, 9'd12, 1);
    sl = 0; step();
    send(2'b11, 1'b0, 2'd1, 9'd5, 0);
    chk("R8 frozen", m_div, 12);
    mfb_in = 1; #1 chk("R9 sel10 mfb1", test_out, 1);
    mfb_in = 0; #1 chk("R9 sel10 mfb0", test_out, 0);
    @(negedge clk);

    sl = 1; step(); sl = 0; step();
    fout_in = 1; #1 chk("R9 sel11 fout", test_out, 1);
    @(negedge clk);
    par_m = 22; pl_n = 0; #1 chk("R10 test low", test_out, 0);
    step();
    pl_n = 1; step();
    send(2'b00, 1'b0, 2'd2, 9'd11, 0);
    pl_n = 0; step();
    par_m = 23; pl_n = 1; sl = 1; step();
    chk("R12 parallel wins", m_div, 23);
    sl = 0; step();
    sl = 1; step();
    chk("R13 serial over parallel", m_div, 11);
    chk("R13 n", n_div, 2);
    sl = 0; step();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule